// File: doc/BRIEF.md
# Washer Cycle Controller with BCD Countdown

This block is the control core of a washing appliance. In standby the user steps through the function codes with a mode key and raises a preset run time one second per press of a time key. A start command then enters the selected working function (wash, rinse or dry). The block drives the matching drive line and counts the remaining time down, one second per tick, as four BCD digits holding minutes and seconds. When the count reaches zero the block goes back to standby by itself.

A pause input freezes the countdown in a paused state without losing the remaining time. Releasing pause resumes the interrupted function. A stop input returns the block to standby at once, without waiting for a clock edge. The display outputs carry either the preset values or the running values, selected by a flag. Seven-segment decoding and digit scanning belong to a separate display driver.

Top module: `wash_cycle_ctrl`

## Requirements
- R1: After reset the block is in standby: drive_o is 000, mode_o is 000, all four time digits are 0 and show_run_o is 0.
- R2: In standby each cycle with mode_key_i high steps the selected code 000, 001, 010, 011, 100, then back to 000. Outside standby the key has no effect on the selected code.
- R3: In standby each cycle with time_key_i high adds one second to the preset, with BCD carries and seconds tens limited to 0..5. A press at 30:00 gives 00:01. Outside standby the key has no effect on the preset.
- R4: start_i in standby enters the selected function and loads the count from the preset in the same edge, but only when the selected code is 001 (wash), 010 (rinse) or 011 (dry) and the preset is not 00:00. Otherwise start_i is ignored.
- R5: drive_o bit 0 is high only in wash, bit 1 only in rinse and bit 2 only in dry. At most one bit is high at a time.
- R6: In a working function, a cycle with tick_i high and pause_i low lowers the count by one second. A digit at 0 wraps to 9, or to 5 for the seconds tens digit, and borrows from the next higher digit.
- R7: A decrement from 00:01 returns the block to standby.
- R8: pause_i high in a working function enters the paused state (code 100) on the next edge and leaves the count unchanged, even when tick_i is high in the same cycle. While paused, ticks do not change the count.
- R9: In the paused state, pause_i low returns the block on the next edge to the function that was interrupted, with the same remaining time.
- R10: stop_i high forces standby asynchronously and discards the running count. Selection and preset are kept, and the next start loads the count again from the preset.
- R11: show_run_o is 1 in a working or paused state. The time digits then show the count and mode_o shows the state code. In standby the time digits show the preset and mode_o shows the selected code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-second clock enable for the countdown |
| start_i | input | 1 | Start command |
| pause_i | input | 1 | Pause level, high holds the countdown |
| stop_i | input | 1 | Asynchronous stop, active high |
| mode_key_i | input | 1 | Mode step key, single-cycle pulse |
| time_key_i | input | 1 | Time step key, single-cycle pulse |
| drive_o | output | 3 | Function drive lines: bit 0 wash, bit 1 rinse, bit 2 dry |
| mode_o | output | 3 | Mode code for display |
| min_tens_o | output | 4 | BCD minutes tens |
| min_units_o | output | 4 | BCD minutes units |
| sec_tens_o | output | 4 | BCD seconds tens |
| sec_units_o | output | 4 | BCD seconds units |
| show_run_o | output | 1 | 1 selects the running values for display |

## Verification
The functions that can meet in one cycle are the pause request and the one-second decrement. The bench raises pause_i in the same cycle as tick_i, and also with the count at 00:01. The outcome is judged against a model: the block must be paused, the count must be unchanged, and it must not have gone to standby. Key presses and ticks given during a run, and a stop given between clock edges, are also compared with the model on every cycle.

// File: rtl/wcc_pkg.sv
package wcc_pkg;
  localparam int DIGITS = 4;
  typedef logic [3:0] bcd_t;
  typedef bcd_t [DIGITS-1:0] bcd_time_t;  // [0] sec units .. [3] min tens

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WASH  = 3'd1,
    ST_RINSE = 3'd2,
    ST_DRY   = 3'd3,
    ST_HOLD  = 3'd4
  } state_e;

  function automatic bcd_t digit_max(int idx);
    return (idx == 1) ? bcd_t'(5) : bcd_t'(9);
  endfunction
endpackage

// File: rtl/wcc_bcd_digit.sv
module wcc_bcd_digit import wcc_pkg::*; #(
  parameter int MAX = 9
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ld_i,
  input  bcd_t ld_val_i,
  input  logic step_i,
  input  logic down_i,
  output bcd_t val_o
);
  localparam bcd_t TOP = bcd_t'(MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     val_o <= '0;
    else if (ld_i)   val_o <= ld_val_i;
    else if (step_i) begin
      if (down_i) val_o <= (val_o == '0) ? TOP : val_o - 4'd1;
      else        val_o <= (val_o == TOP) ? '0 : val_o + 4'd1;
    end
  end
endmodule

// File: rtl/wcc_bcd_chain.sv
module wcc_bcd_chain import wcc_pkg::*; #(
  parameter bit DOWN = 1'b0
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      ld_i,
  input  bcd_time_t ld_val_i,
  input  logic      step_i,
  output bcd_time_t val_o
);
  logic [DIGITS-1:0] step;
  assign step[0] = step_i;

  for (genvar i = 0; i < DIGITS; i++) begin : g_dig
    wcc_bcd_digit #(.MAX(int'(digit_max(i)))) u_dig (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .ld_i     (ld_i),
      .ld_val_i (ld_val_i[i]),
      .step_i   (step[i]),
      .down_i   (DOWN),
      .val_o    (val_o[i])
    );
    if (i < DIGITS-1) begin : g_ripple
      // borrow on 0, carry on the digit's top value
      assign step[i+1] = step[i] &
        (val_o[i] == (DOWN ? bcd_t'(0) : digit_max(i)));
    end
  end
endmodule

// File: rtl/wcc_setup.sv
module wcc_setup import wcc_pkg::*; #(
  parameter int MAX_MIN = 30
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      en_i,
  input  logic      mode_key_i,
  input  logic      time_key_i,
  output state_e    sel_o,
  output bcd_time_t preset_o
);
  localparam bcd_time_t LIMIT = {bcd_t'(MAX_MIN / 10), bcd_t'(MAX_MIN % 10), 4'd0, 4'd0};
  localparam bcd_time_t ONE_SEC = {4'd0, 4'd0, 4'd0, 4'd1};

  logic time_step, at_limit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_o <= ST_IDLE;
    else if (en_i && mode_key_i) begin
      unique case (sel_o)
        ST_IDLE:  sel_o <= ST_WASH;
        ST_WASH:  sel_o <= ST_RINSE;
        ST_RINSE: sel_o <= ST_DRY;
        ST_DRY:   sel_o <= ST_HOLD;
        default:  sel_o <= ST_IDLE;
      endcase
    end
  end

  assign time_step = en_i & time_key_i;
  assign at_limit  = (preset_o == LIMIT);

  wcc_bcd_chain #(.DOWN(1'b0)) u_preset (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ld_i     (time_step & at_limit),
    .ld_val_i (ONE_SEC),
    .step_i   (time_step),
    .val_o    (preset_o)
  );
endmodule

// File: rtl/wcc_fsm.sv
module wcc_fsm import wcc_pkg::*; (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  logic   pause_i,
  input  logic   tick_i,
  input  state_e sel_i,
  input  logic   preset_nz_i,
  input  logic   cnt_last_i,
  output state_e state_o,
  output logic   load_o,
  output logic   dec_o
);
  state_e state_d, resume_q;
  logic   working;

  assign working = (state_o == ST_WASH) || (state_o == ST_RINSE) || (state_o == ST_DRY);
  assign load_o  = (state_o == ST_IDLE) && start_i && preset_nz_i &&
                   (sel_i == ST_WASH || sel_i == ST_RINSE || sel_i == ST_DRY);
  assign dec_o   = working && !pause_i && tick_i;

  always_comb begin
    state_d = state_o;
    unique case (state_o)
      ST_IDLE: if (load_o) state_d = sel_i;
      ST_HOLD: if (!pause_i) state_d = resume_q;
      default: begin
        if (pause_i)                  state_d = ST_HOLD;
        else if (dec_o && cnt_last_i) state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o  <= ST_IDLE;
      resume_q <= ST_WASH;
    end else begin
      state_o <= state_d;
      if (working && pause_i) resume_q <= state_o;
    end
  end
endmodule

// File: rtl/wash_cycle_ctrl.sv
module wash_cycle_ctrl import wcc_pkg::*; #(
  parameter int MAX_MIN = 30
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       start_i,
  input  logic       pause_i,
  input  logic       stop_i,
  input  logic       mode_key_i,
  input  logic       time_key_i,
  output logic [2:0] drive_o,
  output logic [2:0] mode_o,
  output logic [3:0] min_tens_o,
  output logic [3:0] min_units_o,
  output logic [3:0] sec_tens_o,
  output logic [3:0] sec_units_o,
  output logic       show_run_o
);
  localparam bcd_time_t ONE_SEC = {4'd0, 4'd0, 4'd0, 4'd1};

  state_e    sel, state;
  bcd_time_t preset, count, shown;
  logic      load, dec, run_rst_n;

  // stop acts as an asynchronous clear of the run path only
  assign run_rst_n = rst_ni & ~stop_i;

  wcc_setup #(.MAX_MIN(MAX_MIN)) u_setup (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (state == ST_IDLE),
    .mode_key_i (mode_key_i),
    .time_key_i (time_key_i),
    .sel_o      (sel),
    .preset_o   (preset)
  );

  wcc_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (run_rst_n),
    .start_i     (start_i),
    .pause_i     (pause_i),
    .tick_i      (tick_i),
    .sel_i       (sel),
    .preset_nz_i (preset != '0),
    .cnt_last_i  (count == ONE_SEC),
    .state_o     (state),
    .load_o      (load),
    .dec_o       (dec)
  );

  wcc_bcd_chain #(.DOWN(1'b1)) u_count (
    .clk_i    (clk_i),
    .rst_ni   (run_rst_n),
    .ld_i     (load),
    .ld_val_i (preset),
    .step_i   (dec),
    .val_o    (count)
  );

  assign show_run_o = (state != ST_IDLE);
  assign shown      = show_run_o ? count : preset;
  assign mode_o     = show_run_o ? 3'(state) : 3'(sel);
  assign drive_o    = {state == ST_DRY, state == ST_RINSE, state == ST_WASH};
  assign min_tens_o  = shown[3];
  assign min_units_o = shown[2];
  assign sec_tens_o  = shown[1];
  assign sec_units_o = shown[0];
endmodule

// File: rtl/wcc_checker.sv
module wcc_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       start_i,
  input logic       pause_i,
  input logic       stop_i,
  input logic       mode_key_i,
  input logic       time_key_i,
  input logic [2:0] drive_o,
  input logic [2:0] mode_o,
  input logic [3:0] min_tens_o,
  input logic [3:0] min_units_o,
  input logic [3:0] sec_tens_o,
  input logic [3:0] sec_units_o,
  input logic       show_run_o
);
  logic [11:0] secs;
  assign secs = 12'(min_tens_o) * 12'd600 + 12'(min_units_o) * 12'd60 +
                12'(sec_tens_o) * 12'd10 + 12'(sec_units_o);

  assert_drive_onehot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(drive_o));

  assert_drive_in_work_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drive_o != 3'b000) |-> (show_run_o && mode_o != 3'd4 && mode_o != 3'd0));

  assert_bad_start_ignored_R4: assert property (@(posedge clk_i) disable iff (!rst_ni || stop_i)
    (!show_run_o && start_i && (mode_o == 3'd0 || mode_o == 3'd4)) |=> !show_run_o);

  assert_hold_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni || stop_i)
    (show_run_o && mode_o == 3'd4 && pause_i) |=>
      (!show_run_o || $stable(secs)));

  assert_count_not_rising_R6: assert property (@(posedge clk_i) disable iff (!rst_ni || stop_i)
    (show_run_o && $past(show_run_o)) |-> (secs <= $past(secs)));

  assert_preset_limit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !show_run_o |-> (secs <= 12'd1800 && sec_tens_o <= 4'd5));
endmodule

bind wash_cycle_ctrl wcc_checker u_chk (.*);

// File: tb/wash_cycle_ctrl_test.sv
module wash_cycle_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 0, start = 0, pause = 0, stop = 0, mkey = 0, tkey = 0;
  logic [2:0] drive, mode;
  logic [3:0] mt, mu, st, su;
  logic show_run;

  always #2.5 clk = ~clk;

  wash_cycle_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .start_i(start), .pause_i(pause),
    .stop_i(stop), .mode_key_i(mkey), .time_key_i(tkey), .drive_o(drive),
    .mode_o(mode), .min_tens_o(mt), .min_units_o(mu), .sec_tens_o(st),
    .sec_units_o(su), .show_run_o(show_run)
  );

  int checks = 0, fails = 0, cycles = 0;
  string tag = "R1";
  bit done = 0;

  // reference model
  int m_state = 0, m_sel = 0, m_pre = 0, m_cnt = 0, m_res = 1;

  always @(posedge clk) begin
    if (rst_n && !stop) begin
      case (m_state)
        0: begin
          if (start && m_sel >= 1 && m_sel <= 3 && m_pre != 0) begin
            m_state = m_sel; m_cnt = m_pre;
          end
          if (mkey) m_sel = (m_sel + 1) % 5;
          if (tkey) m_pre = (m_pre == 1800) ? 1 : m_pre + 1;
        end
        4: if (!pause) m_state = m_res;
        default: begin
          if (pause) begin m_res = m_state; m_state = 4; end
          else if (tick) begin
            m_cnt = m_cnt - 1;
            if (m_cnt == 0) m_state = 0;
          end
        end
      endcase
    end
  end

  task automatic compare();
    int v, e_drv, e_mode, e_run;
    logic [15:0] e_t, a_t;
    v = (m_state != 0) ? m_cnt : m_pre;
    e_t = {4'(v / 600), 4'((v / 60) % 10), 4'((v % 60) / 10), 4'(v % 10)};
    a_t = {mt, mu, st, su};
    e_run = (m_state != 0) ? 1 : 0;
    e_mode = (m_state != 0) ? m_state : m_sel;
    e_drv = (m_state == 1) ? 1 : (m_state == 2) ? 2 : (m_state == 3) ? 4 : 0;
    checks++;
    if (a_t !== e_t || mode !== 3'(e_mode) || drive !== 3'(e_drv) || show_run !== e_run[0]) begin
      fails++;
      $display("FAIL %s cyc %0d: time %h/%h mode %0d/%0d drive %b/%b run %b/%b (act/exp)",
               tag, cycles, a_t, e_t, mode, e_mode, drive, 3'(e_drv), show_run, e_run[0]);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done) compare();
    if (cycles > 150000 && !done) begin
      done = 1; fails++; checks++;
      $display("FAIL watchdog: exp finish, act hung");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic step(input logic t = 0, input logic s = 0, input logic mk = 0, input logic tk = 0);
    @(negedge clk); #1;
    tick = t; start = s; mkey = mk; tkey = tk;
    @(negedge clk); #1;
    tick = 0; start = 0; mkey = 0; tkey = 0;
  endtask

  task automatic do_stop();
    @(negedge clk); #1;
    stop = 1; #0.5;
    m_state = 0; m_cnt = 0;
    tag = "R10"; compare();
    #0.5 stop = 0;
  endtask

  initial begin
    #12 rst_n = 1;
    tag = "R1"; #1 compare();
    tag = "R2"; repeat (3) step(0, 0, 1, 0);          // sel 011 dry
    tag = "R4"; step(0, 1);                            // preset zero: ignored
    tag = "R3"; repeat (5) step(0, 0, 0, 1);           // 00:05
    tag = "R5"; step(0, 1);                            // dry starts
    tag = "R6"; step(1); step(); step(1);              // 00:03
    tag = "R2"; step(0, 0, 1, 1);                      // keys ignored when running
    tag = "R8"; @(negedge clk); #1 pause = 1; tick = 1;
    @(negedge clk); #1 tick = 0; step(1); step(1);
    tag = "R9"; @(negedge clk); #1 pause = 0; step(); step(1); // 00:02
    tag = "R8"; step(1);                               // 00:01
    @(negedge clk); #1 pause = 1; tick = 1;            // pause at 00:01 with tick
    @(negedge clk); #1 tick = 0; pause = 0; step();
    tag = "R7"; step(1); step(1);                      // reaches zero, then idle tick
    tag = "R3"; repeat (1795) step(0, 0, 0, 1);        // 30:00
    step(0, 0, 0, 1);                                  // wraps to 00:01
    repeat (60) step(0, 0, 0, 1);                      // 01:01
    tag = "R2"; repeat (3) step(0, 0, 1, 0);           // 011 -> 100 -> 000 -> 001
    tag = "R4"; step(0, 1);                            // wash starts
    tag = "R6"; repeat (4) step(1);                    // borrow across minutes
    tag = "R3"; step(0, 0, 0, 1);                      // ignored
    do_stop();
    tag = "R10"; step(); step(0, 1);                   // reload 01:01
    tag = "R6"; repeat (70) step(1);                   // to zero
    tag = "R2"; step(0, 0, 1, 0);                      // 010 rinse
    tag = "R11"; step(0, 1); step(1); step(1);
    tag = "R10"; do_stop(); step(1);
    tag = "R4"; repeat (2) step(0, 0, 1, 0); step(0, 1);     // sel 100: ignored
    repeat (4) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule